// File: doc/BRIEF.md
# Paired-Channel Interrupt Status and Mask

This block keeps the interrupt status and interrupt mask for several serial channel pairs. Each pair has two channels: the even-numbered channel is side A and the odd-numbered channel is side B. For each channel the block takes the live transmit-ready and receive-ready flags. It also takes one-cycle break-event pulses and, for each pair, a one-cycle clear-break pulse from the command decoder. A host reads a pair's status byte through a small access port and writes the pair's mask byte through the same port. The block drives one level-sensitive interrupt line for each group of pairs.

The ready bits in the status byte are not stored. They show the channel flags at the moment of the read. The break bits are sticky latches. A break event sets a break bit, and only the pair's clear-break command removes it. A pair requests an interrupt while any status condition is present and its mask bit is set. The requests of the pairs in a group are ORed, then registered, and the result drives that group's line. The line follows the conditions one clock later and drops once no masked condition remains.

Top module: `pair_irq_ctrl`

## Requirements
- R1: After reset every interrupt line is low, `rd_data` is 0x00 and every mask is zero, so ready flags alone raise no interrupt.
- R2: A read of pair p (`stat_rd` high with `acc_sel`=p) loads `rd_data` at the next clock edge. The byte holds, from bit 0 up: A tx-ready, A rx-ready, A break, 0, B tx-ready, B rx-ready, B break, 0. The ready bits are the flags present in the read cycle. Channel 2p is side A and channel 2p+1 is side B.
- R3: A one-cycle `brk_evt` pulse on a channel sets that channel's break bit. The bit stays set after the pulse ends and across any number of reads.
- R4: A `brk_clr` pulse for pair p clears both break bits of pair p and no others. If a break event arrives on a channel in the same cycle as the clear, that channel's break bit ends up set.
- R5: A write (`mask_wr` high) loads `wr_data` into the mask of pair `acc_sel`. Mask bit positions match the status byte bits. Masks of other pairs are unchanged.
- R6: A pair requests an interrupt when, for either of its channels, tx-ready, rx-ready or the break bit is set and the matching mask bit is set. The ready terms use the live flags, not the last read value.
- R7: Interrupt line l is the OR of the requests of pairs l*PAIRS_PER_LINE up to (l+1)*PAIRS_PER_LINE-1. With the defaults, pairs 0 and 1 drive line 0 and pairs 2 and 3 drive line 1.
- R8: A line is registered. It rises or falls at the first clock edge after the masked condition appears or disappears. A break pulse therefore raises the line two edges after the pulse is sampled: one edge to latch the break and one to register the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_ready | input | 2*NUM_PAIRS | Live transmit-ready flag per channel |
| rx_ready | input | 2*NUM_PAIRS | Live receive-ready flag per channel |
| brk_evt | input | 2*NUM_PAIRS | One-cycle break-event pulse per channel |
| brk_clr | input | NUM_PAIRS | One-cycle clear-break command per pair |
| acc_sel | input | SEL_W | Pair addressed by a read or a mask write |
| stat_rd | input | 1 | Status read strobe |
| mask_wr | input | 1 | Mask write strobe |
| wr_data | input | 8 | Mask write data |
| rd_data | output | 8 | Registered status read data |
| irq_line | output | NUM_LINES | Level interrupt line per group of pairs |

## Verification
The assertions assume that every input is known from the first clock of reset. They also assume that `acc_sel` always names an existing pair, and that a read and a mask write never occur in the same cycle. The bench drives every input to zero before reset is released. It changes inputs only in the middle of the clock low phase and issues reads and mask writes as separate single-cycle strobes. Break events and clear commands are driven as single-cycle pulses, as the command logic would produce them.

// File: rtl/pair_irq_pkg.sv
package pair_irq_pkg;

  // Status byte bit positions (mask uses the same positions)
  localparam int unsigned BIT_TX_A  = 0;
  localparam int unsigned BIT_RX_A  = 1;
  localparam int unsigned BIT_BRK_A = 2;
  localparam int unsigned BIT_TX_B  = 4;
  localparam int unsigned BIT_RX_B  = 5;
  localparam int unsigned BIT_BRK_B = 6;

  typedef logic [7:0] stat_byte_t;

  // Assemble the status byte of a pair from its channel flags
  function automatic stat_byte_t build_status(input logic [1:0] txr,
                                              input logic [1:0] rxr,
                                              input logic [1:0] brk);
    stat_byte_t s;
    s            = '0;
    s[BIT_TX_A]  = txr[0];
    s[BIT_RX_A]  = rxr[0];
    s[BIT_BRK_A] = brk[0];
    s[BIT_TX_B]  = txr[1];
    s[BIT_RX_B]  = rxr[1];
    s[BIT_BRK_B] = brk[1];
    return s;
  endfunction

  // A pair requests service when any enabled condition is present
  function automatic logic masked_any(input stat_byte_t s, input stat_byte_t m);
    return |(s & m);
  endfunction

endpackage

// File: rtl/pair_slot.sv
module pair_slot
  import pair_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] txr,
  input  logic [1:0] rxr,
  input  logic [1:0] evt,
  input  logic       clr,
  input  logic       mask_we,
  input  logic [7:0] wdata,
  output logic [7:0] status,
  output logic       req,
  output logic [1:0] brk,
  output logic [7:0] mask
);

  logic [1:0] brk_q;
  logic [7:0] mask_q;

  // Sticky break latches: an event in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_q <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        brk_q[i] <= evt[i] | (brk_q[i] & ~clr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wdata;
  end

  always_comb begin
    status = build_status(txr, rxr, brk_q);
    req    = masked_any(status, mask_q);
  end

  assign brk  = brk_q;
  assign mask = mask_q;

endmodule

// File: rtl/line_merge.sv
module line_merge #(
  parameter int unsigned NUM_PAIRS      = 4,
  parameter int unsigned PAIRS_PER_LINE = 2,
  localparam int unsigned NUM_LINES     = (NUM_PAIRS + PAIRS_PER_LINE - 1) / PAIRS_PER_LINE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PAIRS-1:0] pair_req,
  output logic [NUM_LINES-1:0] irq_q
);

  logic [NUM_LINES-1:0] line_d;

  always_comb begin
    line_d = '0;
    for (int p = 0; p < int'(NUM_PAIRS); p++) begin
      line_d[p / PAIRS_PER_LINE] = line_d[p / PAIRS_PER_LINE] | pair_req[p];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= line_d;
  end

endmodule

// File: rtl/pair_irq_ctrl.sv
module pair_irq_ctrl
  import pair_irq_pkg::*;
#(
  parameter int unsigned NUM_PAIRS      = 4,
  parameter int unsigned PAIRS_PER_LINE = 2,
  localparam int unsigned NUM_CH        = 2 * NUM_PAIRS,
  localparam int unsigned SEL_W         = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
  localparam int unsigned NUM_LINES     = (NUM_PAIRS + PAIRS_PER_LINE - 1) / PAIRS_PER_LINE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CH-1:0]    tx_ready,
  input  logic [NUM_CH-1:0]    rx_ready,
  input  logic [NUM_CH-1:0]    brk_evt,
  input  logic [NUM_PAIRS-1:0] brk_clr,
  input  logic [SEL_W-1:0]     acc_sel,
  input  logic                 stat_rd,
  input  logic                 mask_wr,
  input  logic [7:0]           wr_data,
  output logic [7:0]           rd_data,
  output logic [NUM_LINES-1:0] irq_line
);

  // Named internal events, visible to the bound checker
  logic [NUM_PAIRS-1:0]   pair_req;
  logic [NUM_CH-1:0]      brk_latch;
  logic [8*NUM_PAIRS-1:0] mask_flat;
  logic [8*NUM_PAIRS-1:0] stat_flat;
  logic [NUM_PAIRS-1:0]   mask_we_vec;
  logic [7:0]             rd_next;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign mask_we_vec[p] = mask_wr && (acc_sel == SEL_W'(p));

    pair_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .txr     (tx_ready[2*p +: 2]),
      .rxr     (rx_ready[2*p +: 2]),
      .evt     (brk_evt[2*p +: 2]),
      .clr     (brk_clr[p]),
      .mask_we (mask_we_vec[p]),
      .wdata   (wr_data),
      .status  (stat_flat[8*p +: 8]),
      .req     (pair_req[p]),
      .brk     (brk_latch[2*p +: 2]),
      .mask    (mask_flat[8*p +: 8])
    );
  end

  // Read mux: merged status of the addressed pair
  always_comb begin
    rd_next = '0;
    for (int p = 0; p < int'(NUM_PAIRS); p++) begin
      if (acc_sel == SEL_W'(p)) rd_next = stat_flat[8*p +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_data <= '0;
    else if (stat_rd) rd_data <= rd_next;
  end

  line_merge #(
    .NUM_PAIRS      (NUM_PAIRS),
    .PAIRS_PER_LINE (PAIRS_PER_LINE)
  ) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pair_req (pair_req),
    .irq_q    (irq_line)
  );

endmodule

// File: rtl/pair_irq_chk.sv
module pair_irq_chk #(
  parameter int unsigned NUM_PAIRS      = 4,
  parameter int unsigned PAIRS_PER_LINE = 2,
  localparam int unsigned NUM_CH        = 2 * NUM_PAIRS,
  localparam int unsigned SEL_W         = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
  localparam int unsigned NUM_LINES     = (NUM_PAIRS + PAIRS_PER_LINE - 1) / PAIRS_PER_LINE
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_CH-1:0]      tx_ready,
  input logic [NUM_CH-1:0]      brk_evt,
  input logic [NUM_PAIRS-1:0]   brk_clr,
  input logic [SEL_W-1:0]       acc_sel,
  input logic                   stat_rd,
  input logic                   mask_wr,
  input logic [7:0]             rd_data,
  input logic [NUM_LINES-1:0]   irq_line,
  input logic [NUM_PAIRS-1:0]   pair_req,
  input logic [NUM_CH-1:0]      brk_latch,
  input logic [8*NUM_PAIRS-1:0] mask_flat
);

  logic [NUM_CH-1:0]    clr_ch;
  logic [NUM_LINES-1:0] exp_line;
  logic                 sel_tx_a;

  always_comb begin
    clr_ch   = '0;
    exp_line = '0;
    sel_tx_a = 1'b0;
    for (int c = 0; c < int'(NUM_CH); c++) clr_ch[c] = brk_clr[c / 2];
    for (int p = 0; p < int'(NUM_PAIRS); p++) begin
      if (pair_req[p]) exp_line[p / PAIRS_PER_LINE] = 1'b1;
      if (acc_sel == SEL_W'(p)) sel_tx_a = tx_ready[2*p];
    end
  end

  assert_brk_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_latch & ~$past(brk_latch) & ~$past(brk_evt)) == '0);

  assert_brk_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(brk_latch) & ~brk_latch & ~($past(clr_ch) & ~$past(brk_evt))) == '0);

  assert_brk_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_ch) & ~$past(brk_evt) & brk_latch) == '0);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] == 1'b0) && (rd_data[7] == 1'b0));

  assert_read_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stat_rd) |-> (rd_data[0] == $past(sel_tx_a)));

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mask_wr) |-> $stable(mask_flat));

  assert_line_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line == $past(exp_line));

endmodule

bind pair_irq_ctrl pair_irq_chk #(
  .NUM_PAIRS      (NUM_PAIRS),
  .PAIRS_PER_LINE (PAIRS_PER_LINE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_ready  (tx_ready),
  .brk_evt   (brk_evt),
  .brk_clr   (brk_clr),
  .acc_sel   (acc_sel),
  .stat_rd   (stat_rd),
  .mask_wr   (mask_wr),
  .rd_data   (rd_data),
  .irq_line  (irq_line),
  .pair_req  (pair_req),
  .brk_latch (brk_latch),
  .mask_flat (mask_flat)
);

// File: tb/sim_pair_irq_ctrl.sv
module sim_pair_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_ready = '0;
  logic [7:0] rx_ready = '0;
  logic [7:0] brk_evt = '0;
  logic [3:0] brk_clr = '0;
  logic [1:0] acc_sel = '0;
  logic       stat_rd = 1'b0;
  logic       mask_wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] irq_line;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  pair_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .rx_ready(rx_ready),
    .brk_evt(brk_evt), .brk_clr(brk_clr), .acc_sel(acc_sel),
    .stat_rd(stat_rd), .mask_wr(mask_wr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_line(irq_line)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Advance to just after the next rising edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic read_pair(input int p, output logic [7:0] v);
    acc_sel = 2'(p);
    stat_rd = 1'b1;
    tick();
    stat_rd = 1'b0;
    v = rd_data;
  endtask

  task automatic write_mask(input int p, input logic [7:0] m);
    acc_sel = 2'(p);
    wr_data = m;
    mask_wr = 1'b1;
    tick();
    mask_wr = 1'b0;
  endtask

  task automatic pulse_brk(input logic [7:0] ev, input logic [3:0] cl);
    brk_evt = ev;
    brk_clr = cl;
    tick();
    brk_evt = '0;
    brk_clr = '0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check(irq_line == 2'b00, "R1 irq after reset", irq_line, 0);
    check(rd_data == 8'h00, "R1 rd_data after reset", rd_data, 0);
    tx_ready = 8'hFF;
    rx_ready = 8'hFF;
    tick(); tick();
    check(irq_line == 2'b00, "R1 flags unmasked", irq_line, 0);
    read_pair(0, v);
    check(v == 8'h33, "R2 all ready flags", v, 8'h33);
    tx_ready = '0;
    rx_ready = '0;
  endtask

  task automatic t_layout();
    logic [7:0] v;
    tx_ready = 8'b0000_0001; // ch0 A tx
    rx_ready = 8'b0000_1000; // ch3 pair1 B rx
    read_pair(0, v);
    check(v == 8'h01, "R2 pair0 layout", v, 8'h01);
    read_pair(1, v);
    check(v == 8'h20, "R2 pair1 layout", v, 8'h20);
    tx_ready = 8'b1000_0000; // ch7 pair3 B tx
    rx_ready = 8'b0100_0000; // ch6 pair3 A rx
    read_pair(3, v);
    check(v == 8'h12, "R2 pair3 live flags", v, 8'h12);
    tx_ready = '0;
    rx_ready = '0;
  endtask

  task automatic t_break();
    logic [7:0] v;
    pulse_brk(8'b0010_0000, 4'b0000); // ch5 pair2 B
    tick();
    read_pair(2, v);
    check(v == 8'h40, "R3 break latched", v, 8'h40);
    read_pair(2, v);
    check(v == 8'h40, "R3 break survives read", v, 8'h40);
    pulse_brk(8'b0000_0001, 4'b0000); // ch0 pair0 A
    read_pair(0, v);
    check(v == 8'h04, "R3 break A position", v, 8'h04);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    pulse_brk(8'b0001_0000, 4'b0000); // ch4 too
    pulse_brk(8'h00, 4'b0100);        // clear pair2
    read_pair(2, v);
    check(v == 8'h00, "R4 pair2 cleared", v, 8'h00);
    read_pair(0, v);
    check(v == 8'h04, "R4 pair0 untouched", v, 8'h04);
    pulse_brk(8'b0000_0010, 4'b0001); // clear pair0 + event ch1 same cycle
    read_pair(0, v);
    check(v == 8'h40, "R4 event wins over clear", v, 8'h40);
    pulse_brk(8'h00, 4'b0001);
    read_pair(0, v);
    check(v == 8'h00, "R4 pair0 clear", v, 8'h00);
  endtask

  task automatic t_mask_irq();
    write_mask(1, 8'h01);            // pair1 A tx
    tx_ready[2] = 1'b1;
    check(irq_line == 2'b00, "R8 not before edge", irq_line, 0);
    tick();
    check(irq_line == 2'b01, "R6 R7 pair1 on line0", irq_line, 1);
    tx_ready[3] = 1'b1;             // B tx, masked out
    tx_ready[2] = 1'b0;
    tick();
    check(irq_line == 2'b00, "R8 falls when condition gone", irq_line, 0);
    write_mask(3, 8'h20);            // pair3 B rx
    check(irq_line == 2'b00, "R5 mask alone no irq", irq_line, 0);
    rx_ready[7] = 1'b1;
    tick();
    check(irq_line == 2'b10, "R7 pair3 on line1", irq_line, 2);
    rx_ready[7] = 1'b0;
    tick();
    write_mask(0, 8'h44);            // pair0 breaks
    pulse_brk(8'b0000_0010, 4'b0000);
    check(irq_line == 2'b00, "R8 break needs two edges", irq_line, 0);
    tick();
    check(irq_line == 2'b01, "R6 break raises line0", irq_line, 1);
    pulse_brk(8'h00, 4'b0001);
    tick();
    check(irq_line == 2'b00, "R4 clear drops irq", irq_line, 0);
    write_mask(2, 8'h02);            // pair2 A rx
    rx_ready[4] = 1'b1;
    tick();
    check(irq_line == 2'b10, "R7 pair2 on line1", irq_line, 2);
    write_mask(2, 8'h00);
    tick();
    check(irq_line == 2'b00, "R5 unmask drops irq", irq_line, 0);
    rx_ready[4] = 1'b0;
    tx_ready = '0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_layout();
    t_break();
    t_clear();
    t_mask_irq();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule